// File: doc/BRIEF.md
# Fractional-N Ratio Delta-Sigma Controller

This block produces, once per reference-rate strobe, the integer feedback divide value for a fractional-N frequency loop. Software supplies an unsigned fixed-point ratio of output frequency to undivided reference frequency. It also supplies a power-of-two scale select and the reference pre-divider select. The block applies the scale and then multiplies by the pre-divider factor, so the loop compares against the divided reference and the programmed ratio stays the same. The result is a corrected ratio with a wide integer part.

A first-order digital accumulator holds the fractional part of the corrected ratio. Each strobe that it overflows adds one to the integer part. The emitted divide value therefore alternates between the floor of the ratio and the floor plus one, and its long-run average equals the corrected ratio exactly. The block raises a flag when the scaled ratio no longer fits the integer field of the ratio format. Any change of the configuration gives a one-cycle pulse, which the lock logic downstream uses to force its status to unlocked.

Top module: `frac_ratio_dsm`

## Requirements
- R1: Over any run of 2^FRAC_W consecutive accepted strobes, the sum of the div_o values equals the corrected ratio expressed as an integer count of 2^-FRAC_W units.
- R2: mod_sel_i values 0 to 3 multiply the ratio by 1, 2, 4 and 8. Values 4 to 7 divide it by 2, 4, 8 and 16, and the fraction bits shifted below FRAC_W are dropped.
- R3: div_sel_i value 0 multiplies the scaled ratio by 4, value 1 multiplies it by 2, and value 2 leaves it unchanged. The reserved value 3 acts like value 2.
- R4: After an accepted strobe, div_o is either the integer part of the corrected ratio or that value plus one.
- R5: ovf_o is high when the scaled ratio (before the pre-divider factor) has an integer part of 2^INT_W or more, and it is valid from the cycle after the configuration is sampled. A right shift never raises it. The divide output keeps full precision even while ovf_o is high.
- R6: chg_o is high for the one cycle that follows a clock edge at which ratio_i, mod_sel_i or div_sel_i differs from the value sampled at the previous edge. chg_o is low when all three are unchanged.
- R7: At an edge where a configuration change is detected, the accumulator restarts from zero and a strobe in that cycle is dropped (div_o is held). The first accepted strobe after the change gives exactly the integer part.
- R8: div_o changes only at edges where ref_strobe_i is high.
- R9: While rst_n is low, div_o is 0 and chg_o and ovf_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_i | input | INT_W+FRAC_W (32) | Unsigned fixed-point output/input frequency ratio |
| mod_sel_i | input | 3 | Power-of-two scale select |
| div_sel_i | input | 2 | Reference pre-divider select |
| ref_strobe_i | input | 1 | One pulse per reference cycle |
| div_o | output | 2*INT_W (24) | Integer feedback divide value |
| ovf_o | output | 1 | Scaled ratio exceeds the integer field |
| chg_o | output | 1 | One-cycle configuration change pulse |

## Verification
A wrong accumulator value or a lost carry leaves each divide value plausible but shifts the sum over one full accumulator period. Each period is checked against the arithmetic expectation, so the error is reported within 2^FRAC_W strobes. A wrong shift or pre-divider decode moves the integer part, and the first strobe after a change shows it at once. A stale configuration register shows up as a missing or extra change pulse, or a wrong overflow flag, one cycle after the inputs move. The bench uses a narrow ratio format so that every scale and divider setting can be swept against several ratios within full accumulator periods.

// File: rtl/frac_ratio_dsm.sv
module frac_ratio_dsm #(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [INT_W+FRAC_W-1:0]    ratio_i,
  input  logic [2:0]                 mod_sel_i,
  input  logic [1:0]                 div_sel_i,
  input  logic                       ref_strobe_i,
  output logic [2*INT_W-1:0]         div_o,
  output logic                       ovf_o,
  output logic                       chg_o
);
  localparam int RW    = INT_W + FRAC_W;
  localparam int CI_W  = 2 * INT_W;
  localparam int CW    = CI_W + FRAC_W;
  localparam int CFG_W = RW + 5;

  logic [CFG_W-1:0]  cfg_in, cfg_q;
  logic [RW-1:0]     ratio_q;
  logic [2:0]        mod_q;
  logic [1:0]        div_q;
  logic [1:0]        lsh, dsh;
  logic [2:0]        rsh;
  logic [CW-1:0]     eff, corr;
  logic [CI_W-1:0]   corr_int;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   acc_sum;
  logic              changed;

  assign cfg_in = {ratio_i, mod_sel_i, div_sel_i};
  assign {ratio_q, mod_q, div_q} = cfg_q;
  assign changed = (cfg_in != cfg_q);

  assign lsh = mod_q[2] ? 2'd0 : mod_q[1:0];
  assign rsh = mod_q[2] ? ({1'b0, mod_q[1:0]} + 3'd1) : 3'd0;
  assign dsh = (div_q == 2'b00) ? 2'd2 : (div_q == 2'b01) ? 2'd1 : 2'd0;

  assign eff      = ({{(CW-RW){1'b0}}, ratio_q} << lsh) >> rsh;
  assign corr     = eff << dsh;
  assign corr_int = corr[CW-1:FRAC_W];
  assign ovf_o    = |eff[CW-1:RW];
  assign acc_sum  = {1'b0, acc} + {1'b0, corr[FRAC_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      chg_o <= 1'b0;
      acc   <= '0;
      div_o <= '0;
    end else begin
      cfg_q <= cfg_in;
      chg_o <= changed;
      if (changed) begin
        acc <= '0;
      end else if (ref_strobe_i) begin
        acc   <= acc_sum[FRAC_W-1:0];
        div_o <= corr_int + CI_W'(acc_sum[FRAC_W]);
      end
    end
  end

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ref_strobe_i) |-> $stable(div_o));

  // R4
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_strobe_i && !changed) |=> ((div_o - $past(corr_int)) <= CI_W'(1)));

  // R7
  acc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |-> (acc == '0));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_q[2] |-> !ovf_o);

  // R6
  no_spurious_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_in == cfg_q) |=> !chg_o);
endmodule

// File: tb/tb_frac_ratio_dsm.sv
module tb_frac_ratio_dsm;
  localparam int INT_W  = 6;
  localparam int FRAC_W = 8;
  localparam int RW     = INT_W + FRAC_W;
  localparam int CI_W   = 2 * INT_W;
  localparam int PERIOD = 1 << FRAC_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [RW-1:0]   ratio_i = '0;
  logic [2:0]      mod_sel_i = '0;
  logic [1:0]      div_sel_i = '0;
  logic            ref_strobe_i = 1'b0;
  logic [CI_W-1:0] div_o;
  logic            ovf_o, chg_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  frac_ratio_dsm #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut (
    .clk(clk), .rst_n(rst_n), .ratio_i(ratio_i), .mod_sel_i(mod_sel_i),
    .div_sel_i(div_sel_i), .ref_strobe_i(ref_strobe_i),
    .div_o(div_o), .ovf_o(ovf_o), .chg_o(chg_o));

  always #10 clk = ~clk;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint scaled(longint r, int m);
    if (m < 4) return r << m;
    return r >> (m - 3);
  endfunction

  function automatic longint corr_of(longint r, int m, int d);
    longint e = scaled(r, m);
    if (d == 0) return e * 4;
    if (d == 1) return e * 2;
    return e;
  endfunction

  longint ratios[6] = '{14'h0101, 14'h3FFF, 14'h0480, 14'h2000, 14'h07F3, 14'h1234};

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint exp_c, sum, fl, held;
    bit range_ok;
    ratio_i = 14'h0155; mod_sel_i = 3'd1; div_sel_i = 2'd0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(div_o == 0, "R9 div_o in reset", div_o, 0);
    chk(chg_o == 0, "R9 chg_o in reset", chg_o, 0);
    chk(ovf_o == 0, "R9 ovf_o in reset", ovf_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    foreach (ratios[ri]) begin
      for (int m = 0; m < 8; m++) begin
        for (int d = 0; d < 4; d++) begin
          ratio_i = ratios[ri][RW-1:0]; mod_sel_i = m[2:0]; div_sel_i = d[1:0];
          @(negedge clk);
          // R6: change pulse
          chk(chg_o == 1, "R6 chg pulse on change", chg_o, 1);
          @(negedge clk);
          chk(chg_o == 0, "R6 chg pulse one cycle", chg_o, 0);
          // R5: overflow flag
          chk(ovf_o == (scaled(ratios[ri], m) >= (longint'(1) << RW)),
              "R5 ovf flag", ovf_o, scaled(ratios[ri], m) >= (longint'(1) << RW));
          exp_c = corr_of(ratios[ri], m, d);
          fl = exp_c >> FRAC_W;
          sum = 0;
          range_ok = 1;
          ref_strobe_i = 1'b1;
          for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            sum += div_o;
            // R7: first strobe after restart gives the floor
            if (i == 0) chk(div_o == fl, "R7 first div after change", div_o, fl);
            if (!(div_o == fl || div_o == fl + 1)) range_ok = 0;
          end
          ref_strobe_i = 1'b0;
          // R4
          chk(range_ok, "R4 div in floor..floor+1", range_ok, 1);
          // R1, R2, R3: exact period sum
          chk(sum == exp_c, "R1/R2/R3 period sum", sum, exp_c);
          held = div_o;
          repeat (3) @(negedge clk);
          // R8
          chk(div_o == held, "R8 div held without strobe", div_o, held);
        end
      end
    end

    // R6: same config applied again gives no pulse
    ratio_i = ratio_i;
    @(negedge clk);
    chk(chg_o == 0, "R6 no pulse when unchanged", chg_o, 0);

    // R7: strobe coinciding with a change is dropped
    held = div_o;
    ratio_i = 14'h0A55; mod_sel_i = 3'd0; div_sel_i = 2'd2; ref_strobe_i = 1'b1;
    @(negedge clk);
    ref_strobe_i = 1'b0;
    chk(div_o == held, "R7 strobe dropped at change", div_o, held);
    @(negedge clk);
    ref_strobe_i = 1'b1;
    @(negedge clk);
    ref_strobe_i = 1'b0;
    chk(div_o == (14'h0A55 >> FRAC_W), "R7 floor after dropped strobe", div_o, 14'h0A55 >> FRAC_W);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule